// File: doc/BRIEF.md
# Interrupt destination resolver

The resolver converts an interrupt command into the set of processors that should receive it. It holds a small table with one entry for each target processor. Each entry carries a programmable physical ID, a logical destination byte, a destination model nibble, and an arbitration ID. A sender issues a message by writing a 32-bit command word in two halves. Writing the high half stores the destination byte. Writing the low half decodes the vector, delivery mode, addressing mode, level, trigger and shorthand fields, and starts a resolution at once.

Resolution uses several inputs. Physical or logical addressing chooses the candidates; in logical addressing each target applies either a flat or a cluster match, according to its own model nibble. A shorthand code can override the destination field. The delivery mode then shapes the result: lowest-priority delivery keeps one target, the reserved mode delivers nothing, and an INIT deassert delivers nothing but loads each addressed target's arbitration ID from its physical ID. The outcome appears one clock after the low write, as a single-cycle valid pulse carrying the target mask and the message fields. The pulse is withheld when the mask is empty.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical addressing (command bit 11 = 0, shorthand 0), destination byte 0xFF selects every target.
- R2: In physical addressing, any other destination selects only the lowest-numbered target whose ID equals it; with no match nothing is delivered. After reset, target i holds ID i.
- R3: In logical addressing (bit 11 = 1), a target whose model nibble is 0xF is selected when the destination AND its logical byte is nonzero.
- R4: In logical addressing, a target with model nibble 0x0 is selected when the destination's upper nibble equals its logical byte's upper nibble and the lower nibbles share a set bit; a target with any other model value is never selected logically.
- R5: Shorthand (bits 19:18): 0 uses the destination, 1 selects only the sender, 2 selects all targets, 3 selects all targets except the sender.
- R6: Low command word fields: vector 7:0, delivery mode 10:8, addressing mode 11, level 14, trigger 15. The destination is bits 31:24 of the high word. A high write alone only stores the destination. A low write produces its result one clock later, with vector, mode, addressing mode, level and trigger passed through unchanged.
- R7: Delivery mode 1 (lowest priority) reduces the mask to its lowest-numbered set bit.
- R8: Delivery mode 5 with level 0 and trigger 1 delivers nothing. On the same clock edge it copies the ID of each addressed target into that target's arbitration ID, and leaves the other arbitration IDs unchanged. INIT with any other level/trigger combination delivers normally.
- R9: Delivery mode 3 never produces a delivery. Modes 0, 2 (SMI), 4 (NMI), 6 (startup) and 7 (external) deliver the full addressed mask.
- R10: Valid is a single-cycle pulse following a low write. It is never raised with an empty mask, and the mask reads zero while valid is low.
- R11: Reset clears valid, mask and all arbitration IDs. It also sets each logical byte to 0 and each model nibble to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one target table entry |
| cfg_sel | input | IDX_W | Target index to write |
| cfg_id | input | 8 | Physical ID to store |
| cfg_ldr | input | 8 | Logical destination byte to store |
| cfg_model | input | 4 | Destination model nibble to store |
| cmd_hi_we | input | 1 | Store the high command word |
| cmd_lo_we | input | 1 | Write the low command word and send |
| cmd_wdata | input | 32 | Command word data |
| sender_idx | input | IDX_W | Index of the sending target |
| out_valid | output | 1 | Delivery pulse |
| out_mask | output | NUM_TGT | Selected targets |
| out_vector | output | 8 | Vector passed through |
| out_dlv | output | 3 | Delivery mode passed through |
| out_dest_mode | output | 1 | Addressing mode passed through |
| out_level | output | 1 | Level bit passed through |
| out_trig | output | 1 | Trigger bit passed through |
| arb_ids | output | 8*NUM_TGT | Arbitration IDs, target i in bits 8i+7:8i |

## Verification
Each delivery result is due on the first rising edge after the low write: valid, mask and fields are all registered there. The arbitration IDs change on that same edge. The bench drives every input on a falling edge and samples on the next falling edge, which is half a clock after the result registers. It then samples one falling edge later to confirm that the pulse has ended. Table and high-word writes are made in earlier cycles, so every send resolves against settled configuration.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0]  MODEL_FLAT    = 4'hF;
  localparam logic [3:0]  MODEL_CLUSTER = 4'h0;
  localparam logic [7:0]  DEST_EVERY    = 8'hFF;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1,
    DLV_SMI    = 3'd2,
    DLV_RSVD   = 3'd3,
    DLV_NMI    = 3'd4,
    DLV_INIT   = 3'd5,
    DLV_START  = 3'd6,
    DLV_EXT    = 3'd7
  } dlv_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] dest;
    shorthand_e sh;
    logic       trig;
    logic       level;
    logic       dmode;
    dlv_e       dlv;
    logic [7:0] vector;
  } msg_t;

  // Split the two command halves into message fields.
  function automatic msg_t decode_msg(input logic [31:0] lo, input logic [31:0] hi);
    msg_t m;
    m.vector = lo[7:0];
    m.dlv    = dlv_e'(lo[10:8]);
    m.dmode  = lo[11];
    m.level  = lo[14];
    m.trig   = lo[15];
    m.sh     = shorthand_e'(lo[19:18]);
    m.dest   = hi[31:24];
    return m;
  endfunction

  // Logical match of one target against a destination byte.
  function automatic logic logical_hit(input logic [7:0] dest, input logic [7:0] ldr,
                                       input logic [3:0] model);
    logic hit;
    case (model)
      MODEL_FLAT:    hit = |(dest & ldr);
      MODEL_CLUSTER: hit = (dest[7:4] == ldr[7:4]) && |(dest[3:0] & ldr[3:0]);
      default:       hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic is_deassert(input msg_t m);
    return (m.dlv == DLV_INIT) && !m.level && m.trig;
  endfunction

endpackage

// File: rtl/idr_target_table.sv
module idr_target_table
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TGT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_sel,
  input  logic [BYTE_W-1:0]             cfg_id,
  input  logic [BYTE_W-1:0]             cfg_ldr,
  input  logic [3:0]                    cfg_model,
  input  logic [NUM_TGT-1:0]            arb_load,
  output logic [NUM_TGT-1:0][BYTE_W-1:0] ids,
  output logic [NUM_TGT-1:0][BYTE_W-1:0] ldrs,
  output logic [NUM_TGT-1:0][3:0]       models,
  output logic [NUM_TGT-1:0][BYTE_W-1:0] arbs
);

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    logic hit_wr;
    assign hit_wr = cfg_we && (cfg_sel == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ids[i]    <= BYTE_W'(i);
        ldrs[i]   <= '0;
        models[i] <= MODEL_FLAT;
      end else if (hit_wr) begin
        ids[i]    <= cfg_id;
        ldrs[i]   <= cfg_ldr;
        models[i] <= cfg_model;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)           arbs[i] <= '0;
      else if (arb_load[i]) arbs[i] <= ids[i];
    end

    AST_ARB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_load[i] |=> $stable(arbs[i])); // R8
    AST_ARB_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      arb_load[i] |=> arbs[i] == $past(ids[i])); // R8
  end

endmodule

// File: rtl/idr_select.sv
module idr_select
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TGT)
) (
  input  msg_t                           msg,
  input  logic [NUM_TGT-1:0][BYTE_W-1:0] ids,
  input  logic [NUM_TGT-1:0][BYTE_W-1:0] ldrs,
  input  logic [NUM_TGT-1:0][3:0]        models,
  input  logic [IDX_W-1:0]               sender,
  output logic [NUM_TGT-1:0]             addr_mask,
  output logic [NUM_TGT-1:0]             final_mask,
  output logic                           deassert
);

  localparam logic [NUM_TGT-1:0] ONE = NUM_TGT'(1);

  function automatic logic [NUM_TGT-1:0] lowest_one(input logic [NUM_TGT-1:0] v);
    return v & (~v + ONE);
  endfunction

  logic [NUM_TGT-1:0] phys_hit, log_hit, dest_mask, self_bit;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_match
    assign phys_hit[i] = (ids[i] == msg.dest);
    assign log_hit[i]  = logical_hit(msg.dest, ldrs[i], models[i]);
  end

  assign self_bit = ONE << sender;
  assign deassert = is_deassert(msg);

  always_comb begin
    if (msg.dmode)                dest_mask = log_hit;
    else if (msg.dest == DEST_EVERY) dest_mask = '1;
    else                          dest_mask = lowest_one(phys_hit);

    case (msg.sh)
      SH_DEST:   addr_mask = dest_mask;
      SH_SELF:   addr_mask = self_bit;
      SH_ALL:    addr_mask = '1;
      default:   addr_mask = ~self_bit;
    endcase

    if (deassert || msg.dlv == DLV_RSVD) final_mask = '0;
    else if (msg.dlv == DLV_LOWEST)      final_mask = lowest_one(addr_mask);
    else                                 final_mask = addr_mask;
  end

endmodule

// File: rtl/idr_out_stage.sv
module idr_out_stage #(
  parameter int unsigned NUM_TGT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               send,
  input  logic [NUM_TGT-1:0] final_mask,
  input  logic [7:0]         vector,
  input  logic [2:0]         dlv,
  input  logic               dmode,
  input  logic               level,
  input  logic               trig,
  output logic               out_valid,
  output logic [NUM_TGT-1:0] out_mask,
  output logic [7:0]         out_vector,
  output logic [2:0]         out_dlv,
  output logic               out_dest_mode,
  output logic               out_level,
  output logic               out_trig
);

  logic fire;
  assign fire = send && (|final_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= fire;
      out_mask  <= fire ? final_mask : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vector    <= '0;
      out_dlv       <= '0;
      out_dest_mode <= 1'b0;
      out_level     <= 1'b0;
      out_trig      <= 1'b0;
    end else if (send) begin
      out_vector    <= vector;
      out_dlv       <= dlv;
      out_dest_mode <= dmode;
      out_level     <= level;
      out_trig      <= trig;
    end
  end

  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0); // R10
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_mask == '0); // R10
  AST_VALID_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    !send |=> !out_valid); // R6

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TGT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_sel,
  input  logic [7:0]                cfg_id,
  input  logic [7:0]                cfg_ldr,
  input  logic [3:0]                cfg_model,
  input  logic                      cmd_hi_we,
  input  logic                      cmd_lo_we,
  input  logic [31:0]               cmd_wdata,
  input  logic [IDX_W-1:0]          sender_idx,
  output logic                      out_valid,
  output logic [NUM_TGT-1:0]        out_mask,
  output logic [7:0]                out_vector,
  output logic [2:0]                out_dlv,
  output logic                      out_dest_mode,
  output logic                      out_level,
  output logic                      out_trig,
  output logic [NUM_TGT*BYTE_W-1:0] arb_ids
);

  logic [31:0] hi_q;
  msg_t        msg;
  logic [NUM_TGT-1:0][BYTE_W-1:0] ids, ldrs, arbs;
  logic [NUM_TGT-1:0][3:0]        models;
  logic [NUM_TGT-1:0]             addr_mask, final_mask, arb_load;
  logic                           deassert;

  always_ff @(posedge clk) begin
    if (!rst_n)         hi_q <= '0;
    else if (cmd_hi_we) hi_q <= cmd_wdata;
  end

  assign msg      = decode_msg(cmd_wdata, hi_q);
  assign arb_load = (cmd_lo_we && deassert) ? addr_mask : '0;
  assign arb_ids  = arbs;

  idr_target_table #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_id(cfg_id), .cfg_ldr(cfg_ldr), .cfg_model(cfg_model),
    .arb_load(arb_load), .ids(ids), .ldrs(ldrs), .models(models), .arbs(arbs)
  );

  idr_select #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_select (
    .msg(msg), .ids(ids), .ldrs(ldrs), .models(models), .sender(sender_idx),
    .addr_mask(addr_mask), .final_mask(final_mask), .deassert(deassert)
  );

  idr_out_stage #(.NUM_TGT(NUM_TGT)) u_out (
    .clk(clk), .rst_n(rst_n), .send(cmd_lo_we), .final_mask(final_mask),
    .vector(msg.vector), .dlv(msg.dlv), .dmode(msg.dmode),
    .level(msg.level), .trig(msg.trig),
    .out_valid(out_valid), .out_mask(out_mask), .out_vector(out_vector),
    .out_dlv(out_dlv), .out_dest_mode(out_dest_mode),
    .out_level(out_level), .out_trig(out_trig)
  );

  AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dlv == DLV_LOWEST) |-> $countones(out_mask) == 1); // R7
  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dlv != DLV_RSVD); // R9
  AST_DEASSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dlv == DLV_INIT) |-> !(!out_level && out_trig)); // R8
  AST_HI_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi_we && !cmd_lo_we) |=> !out_valid); // R6
  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && msg.sh == SH_SELF && msg.dlv == DLV_FIXED)
      |=> out_mask == $past(NUM_TGT'(1) << sender_idx)); // R5

endmodule

// File: tb/test_irq_dest_resolver.sv
`timescale 1ns/1ps
module test_irq_dest_resolver;

  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [7:0] cfg_id = '0, cfg_ldr = '0;
  logic [3:0] cfg_model = '0;
  logic cmd_hi_we = 1'b0, cmd_lo_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [IW-1:0] sender_idx = '0;
  logic out_valid, out_dest_mode, out_level, out_trig;
  logic [N-1:0] out_mask;
  logic [7:0] out_vector;
  logic [2:0] out_dlv;
  logic [N*8-1:0] arb_ids;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_dest_resolver #(.NUM_TGT(N)) i_irq_dest_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_id(cfg_id), .cfg_ldr(cfg_ldr), .cfg_model(cfg_model),
    .cmd_hi_we(cmd_hi_we), .cmd_lo_we(cmd_lo_we), .cmd_wdata(cmd_wdata),
    .sender_idx(sender_idx), .out_valid(out_valid), .out_mask(out_mask),
    .out_vector(out_vector), .out_dlv(out_dlv), .out_dest_mode(out_dest_mode),
    .out_level(out_level), .out_trig(out_trig), .arb_ids(arb_ids)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dm, input logic lvl, input logic trg, input logic [1:0] sh);
    return {12'd0, sh, 2'd0, trg, lvl, 2'd0, dm, dlv, vec};
  endfunction

  task automatic cfg(input int idx, input logic [7:0] id, input logic [7:0] ldr,
                     input logic [3:0] model);
    cfg_we = 1'b1; cfg_sel = IW'(idx); cfg_id = id; cfg_ldr = ldr; cfg_model = model;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_dest(input logic [7:0] dest);
    cmd_hi_we = 1'b1; cmd_wdata = {dest, 24'h00_0000};
    @(posedge clk); @(negedge clk);
    cmd_hi_we = 1'b0;
  endtask

  // Send a low word, check the result one edge later, then check the pulse ended.
  task automatic send(input string req, input logic [31:0] lo, input int snd,
                      input logic exp_v, input logic [N-1:0] exp_m);
    cmd_lo_we = 1'b1; cmd_wdata = lo; sender_idx = IW'(snd);
    @(posedge clk); @(negedge clk);
    cmd_lo_we = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'(exp_v));
    if (exp_v) begin
      chk({req, " mask"}, 64'(out_mask), 64'(exp_m));
      chk({req, " R6 fields"}, {out_vector, out_dlv, out_dest_mode, out_level, out_trig},
          {lo[7:0], lo[10:8], lo[11], lo[14], lo[15]});
    end else begin
      chk({req, " R10 mask idle"}, 64'(out_mask), 64'd0);
    end
    @(posedge clk); @(negedge clk);
    chk({req, " R10 pulse end"}, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R11 valid", 64'(out_valid), 64'd0);
    chk("R11 mask", 64'(out_mask), 64'd0);
    chk("R11 arb ids", 64'(arb_ids), 64'd0);
  endtask

  task automatic t_physical;
    set_dest(8'h02);
    send("R2 reset id", lo_word(8'h31, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h04);
    set_dest(8'h30);
    send("R2 no match", lo_word(8'h31, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b0, 8'h00);
    set_dest(8'hFF);
    send("R1 every", lo_word(8'h41, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0), 0, 1'b1, 8'hFF);
    cfg(3, 8'h55, 8'h00, 4'hF);
    cfg(6, 8'h55, 8'h00, 4'hF);
    set_dest(8'h55);
    send("R2 first match", lo_word(8'h52, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0, 1'b1, 8'h08);
  endtask

  task automatic t_hi_only;
    cmd_hi_we = 1'b1; cmd_wdata = {8'h05, 24'h00_0000};
    @(posedge clk); @(negedge clk);
    cmd_hi_we = 1'b0;
    chk("R6 hi write no send", 64'(out_valid), 64'd0);
    send("R6 stored dest", lo_word(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h20);
  endtask

  task automatic t_logical;
    cfg(0, 8'h00, 8'h01, 4'hF);
    cfg(1, 8'h01, 8'h02, 4'hF);
    cfg(2, 8'h02, 8'h04, 4'hF);
    cfg(3, 8'h55, 8'h81, 4'hF);
    set_dest(8'h05);
    send("R3 flat", lo_word(8'h70, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h0D);
    cfg(4, 8'h04, 8'h23, 4'h0);
    cfg(5, 8'h05, 8'h34, 4'h0);
    cfg(6, 8'h55, 8'hFF, 4'h5);
    set_dest(8'h21);
    send("R4 cluster mix", lo_word(8'h71, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h19);
    set_dest(8'h14);
    send("R4 cluster upper miss", lo_word(8'h72, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h04);
    set_dest(8'h38);
    send("R4 cluster lower miss", lo_word(8'h73, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0), 0, 1'b0, 8'h00);
    set_dest(8'h55);
    send("R2 dup ids", lo_word(8'h74, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h08);
  endtask

  task automatic t_shorthand;
    set_dest(8'h30);
    send("R5 self", lo_word(8'h80, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1), 3, 1'b1, 8'h08);
    send("R5 all", lo_word(8'h81, 3'd0, 1'b0, 1'b1, 1'b0, 2'd2), 3, 1'b1, 8'hFF);
    send("R5 others", lo_word(8'h82, 3'd0, 1'b0, 1'b1, 1'b0, 2'd3), 3, 1'b1, 8'hF7);
    send("R5 others s0", lo_word(8'h83, 3'd0, 1'b0, 1'b1, 1'b0, 2'd3), 0, 1'b1, 8'hFE);
  endtask

  task automatic t_lowest;
    set_dest(8'hFF);
    send("R7 every", lo_word(8'h90, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h01);
    send("R7 others", lo_word(8'h91, 3'd1, 1'b0, 1'b1, 1'b0, 2'd3), 0, 1'b1, 8'h02);
    set_dest(8'h21);
    send("R7 logical", lo_word(8'h92, 3'd1, 1'b1, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'h01);
  endtask

  task automatic t_init;
    set_dest(8'h21);
    send("R8 deassert", lo_word(8'h00, 3'd5, 1'b1, 1'b0, 1'b1, 2'd0), 0, 1'b0, 8'h00);
    chk("R8 arb copy", 64'(arb_ids), 64'h0000_0004_5500_0000);
    set_dest(8'hFF);
    send("R8 init assert", lo_word(8'h00, 3'd5, 1'b0, 1'b1, 1'b1, 2'd0), 0, 1'b1, 8'hFF);
    send("R8 init edge", lo_word(8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0), 0, 1'b1, 8'hFF);
    chk("R8 arb kept", 64'(arb_ids), 64'h0000_0004_5500_0000);
  endtask

  task automatic t_modes;
    set_dest(8'hFF);
    send("R9 reserved", lo_word(8'hA0, 3'd3, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b0, 8'h00);
    send("R9 smi", lo_word(8'hA1, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'hFF);
    send("R9 nmi", lo_word(8'hA2, 3'd4, 1'b0, 1'b1, 1'b0, 2'd0), 0, 1'b1, 8'hFF);
    send("R9 startup", lo_word(8'hA3, 3'd6, 1'b0, 1'b0, 1'b0, 2'd0), 0, 1'b1, 8'hFF);
    send("R9 external", lo_word(8'hA4, 3'd7, 1'b0, 1'b1, 1'b1, 2'd0), 0, 1'b1, 8'hFF);
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_hi_only();
    t_logical();
    t_shorthand();
    t_lowest();
    t_init();
    t_modes();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all R actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule